// File: doc/BRIEF.md
# Sprite Draw and Matrix Refresh Controller

This block accepts sprite drawing commands from a slow processor over a byte-wide strobed input and keeps a one-bit-per-pixel image, 64 columns by 32 rows by default. A draw XORs up to fifteen 8-pixel sprite lines into the image at a given position, wrapping at the edges. When it completes, the block reports whether any lit pixel was turned off, which the processor uses as its collision result.

A separate refresh sequencer runs continuously and independently of the write side. Row by row it selects a row, shifts that row's pixels out serially on a data/clock pair, pulses a latch, and then holds the row lit for a fixed window. Inside that window an output-enable is active for a programmable number of ticks, which sets the brightness. The image storage has one port for the draw logic (read-modify-write) and one for the refresh logic, so drawing never stalls scanning.

Width and height must be powers of two, and the width must be at least 8.

Top module: `disp_ctrl`

## Requirements
- R1: A draw is the byte sequence header, X, Y, then n sprite bytes, where n is header bits [3:0] and header bits [7:4] are ignored; after the last byte the next strobed byte is taken as a new header.
- R2: Sprite byte i is XORed into row Y+i, with its bit 7 landing on column X, bit 6 on column X+1, down to bit 0 on column X+7; pixels whose bit is 0 are unchanged.
- R3: X is taken modulo the width and Y modulo the height (upper byte bits ignored); pixels beyond the right edge wrap to column 0 of the same row, and lines beyond the bottom wrap to row 0.
- R4: `draw_done` is a one-cycle pulse in the cycle after the strobe of a draw's last byte; `coll_flag` is updated then to 1 exactly when that draw turned at least one pixel from 1 to 0, and it holds until the next draw completes or a clear.
- R5: A draw with n = 0 completes on its Y byte, changes no pixel, and reports `coll_flag` = 0.
- R6: A `clr_cmd` cycle turns every pixel off, drives `coll_flag` to 0, abandons any partly received draw, and discards a strobe in the same cycle.
- R7: Refresh visits rows 0, 1, ..., H-1 and repeats; for each row `row_sel` is set, then W pixel bits are shifted out column 0 first, each bit valid in the cycle where `col_sclk` is 1, then `col_latch` is 1 for a single cycle, then a display window of PWM_TICKS cycles follows.
- R8: `row_oe` is 1 for exactly BRIGHT cycles of each display window and is never 1 while `col_sclk` or `col_latch` is 1 or while `row_sel` changes.
- R9: Refresh never waits for the write side; the shifted-out image equals the stored image no later than two full refresh frames after a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Byte strobe, one byte accepted per cycle it is high |
| wr_data | input | 8 | Command byte (header, X, Y or sprite line) |
| clr_cmd | input | 1 | Clear image and abort draw |
| draw_done | output | 1 | One-cycle pulse when a draw completes |
| coll_flag | output | 1 | Collision result of the last completed draw |
| row_sel | output | $clog2(FB_H) | Row being driven |
| col_sdat | output | 1 | Serial column data |
| col_sclk | output | 1 | Serial column clock |
| col_latch | output | 1 | Column register latch pulse |
| row_oe | output | 1 | Row output enable (PWM) |

## Verification
The assertions watch, every cycle, the refresh output discipline: the enable stays dark during shifting, latching and row changes, and the latch is a single-cycle pulse. They also check that the done pulse lasts one cycle, that a clear zeroes the result, and that the collision flag changes only on a completion or a clear. Whether pixels land in the right place with XOR, wrap correctly, and produce the right collision value can only be shown by the bench. It reconstructs the whole image from the serial refresh stream and compares it with its own model after directed corner draws and random ones. The bench also confirms the row order and the exact enable duty per window.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

    // Sprite lines are always one byte wide.
    localparam int SPRITE_BITS = 8;
    localparam int HEIGHT_BITS = 4;

    typedef enum logic [1:0] {
        RX_HDR,
        RX_XPOS,
        RX_YPOS,
        RX_LINES
    } rx_state_e;

    typedef enum logic [1:0] {
        SC_SEL,
        SC_SHIFT,
        SC_LATCH,
        SC_SHOW
    } scan_state_e;

    // Line count carried by a header byte; upper nibble is don't-care.
    function automatic logic [HEIGHT_BITS-1:0] hdr_height(input logic [7:0] b);
        return b[HEIGHT_BITS-1:0];
    endfunction

endpackage

// File: rtl/disp_fb.sv
module disp_fb #(
    parameter int FB_W = 64,
    parameter int FB_H = 32,
    localparam int YW = $clog2(FB_H)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    // draw side: combinational read of the addressed row, XOR write
    input  logic            we,
    input  logic [YW-1:0]   waddr,
    input  logic [FB_W-1:0] wmask,
    output logic [FB_W-1:0] wold,
    // refresh side: independent read
    input  logic [YW-1:0]   raddr,
    output logic [FB_W-1:0] rdata
);

    logic [FB_W-1:0] mem [FB_H];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int r = 0; r < FB_H; r++) begin
                mem[r] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= mem[waddr] ^ wmask;
        end
    end

    assign wold  = mem[waddr];
    assign rdata = mem[raddr];

endmodule

// File: rtl/disp_rx.sv
module disp_rx
    import dispctl_pkg::*;
#(
    parameter int FB_W = 64,
    parameter int FB_H = 32,
    localparam int XW = $clog2(FB_W),
    localparam int YW = $clog2(FB_H)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stb,
    input  logic [7:0]      din,
    input  logic            clr,
    output logic            fb_we,
    output logic [YW-1:0]   fb_waddr,
    output logic [FB_W-1:0] fb_wmask,
    input  logic [FB_W-1:0] fb_old,
    output logic            done,
    output logic            coll
);

    rx_state_e              state_q;
    logic [HEIGHT_BITS-1:0] lines_q;
    logic [HEIGHT_BITS-1:0] idx_q;
    logic [XW-1:0]          x_q;
    logic [YW-1:0]          y_q;
    logic                   acc_q;
    logic                   hit;
    logic                   last_line;

    // Spread one sprite byte over a row, wrapping past the right edge.
    function automatic logic [FB_W-1:0] place_bits(input logic [7:0] b,
                                                   input logic [XW-1:0] x);
        logic [FB_W-1:0] m;
        logic [XW-1:0]   c;
        m = '0;
        for (int k = 0; k < SPRITE_BITS; k++) begin
            c    = x + XW'(k);
            m[c] = b[SPRITE_BITS-1-k];
        end
        return m;
    endfunction

    assign fb_waddr  = y_q + YW'(idx_q);
    assign fb_wmask  = place_bits(din, x_q);
    assign fb_we     = stb && !clr && (state_q == RX_LINES);
    assign hit       = |(fb_old & fb_wmask);
    assign last_line = (idx_q + 1'b1) == lines_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_HDR;
            lines_q <= '0;
            idx_q   <= '0;
            x_q     <= '0;
            y_q     <= '0;
            acc_q   <= 1'b0;
            done    <= 1'b0;
            coll    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (clr) begin
                state_q <= RX_HDR;
                acc_q   <= 1'b0;
                coll    <= 1'b0;
            end else if (stb) begin
                unique case (state_q)
                    RX_HDR: begin
                        lines_q <= hdr_height(din);
                        state_q <= RX_XPOS;
                    end
                    RX_XPOS: begin
                        x_q     <= din[XW-1:0];
                        state_q <= RX_YPOS;
                    end
                    RX_YPOS: begin
                        y_q   <= din[YW-1:0];
                        idx_q <= '0;
                        acc_q <= 1'b0;
                        if (lines_q == '0) begin
                            done    <= 1'b1;
                            coll    <= 1'b0;
                            state_q <= RX_HDR;
                        end else begin
                            state_q <= RX_LINES;
                        end
                    end
                    RX_LINES: begin
                        idx_q <= idx_q + 1'b1;
                        acc_q <= acc_q | hit;
                        if (last_line) begin
                            done    <= 1'b1;
                            coll    <= acc_q | hit;
                            state_q <= RX_HDR;
                        end
                    end
                    default: state_q <= RX_HDR;
                endcase
            end
        end
    end

endmodule

// File: rtl/disp_scan.sv
module disp_scan
    import dispctl_pkg::*;
#(
    parameter int FB_W      = 64,
    parameter int FB_H      = 32,
    parameter int PWM_TICKS = 16,
    parameter int BRIGHT    = 10,
    localparam int YW = $clog2(FB_H),
    localparam int CW = $clog2(FB_W),
    localparam int TW = $clog2(PWM_TICKS)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [YW-1:0]   raddr,
    input  logic [FB_W-1:0] rdata,
    output logic [YW-1:0]   row_sel,
    output logic            col_sdat,
    output logic            col_sclk,
    output logic            col_latch,
    output logic            row_oe
);

    scan_state_e     state_q;
    logic [YW-1:0]   row_q;
    logic [FB_W-1:0] sh_q;
    logic [CW-1:0]   col_q;
    logic            ph_q;
    logic [TW-1:0]   tick_q;

    assign raddr     = row_q;
    assign row_sel   = row_q;
    assign col_sdat  = sh_q[0];
    assign col_sclk  = (state_q == SC_SHIFT) && ph_q;
    assign col_latch = (state_q == SC_LATCH);
    assign row_oe    = (state_q == SC_SHOW) && (int'(tick_q) < BRIGHT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SC_SEL;
            row_q   <= '0;
            sh_q    <= '0;
            col_q   <= '0;
            ph_q    <= 1'b0;
            tick_q  <= '0;
        end else begin
            unique case (state_q)
                SC_SEL: begin
                    sh_q    <= rdata;
                    col_q   <= '0;
                    ph_q    <= 1'b0;
                    state_q <= SC_SHIFT;
                end
                SC_SHIFT: begin
                    if (!ph_q) begin
                        ph_q <= 1'b1;
                    end else begin
                        ph_q  <= 1'b0;
                        sh_q  <= sh_q >> 1;
                        col_q <= col_q + 1'b1;
                        if (col_q == CW'(FB_W - 1)) begin
                            state_q <= SC_LATCH;
                        end
                    end
                end
                SC_LATCH: begin
                    tick_q  <= '0;
                    state_q <= SC_SHOW;
                end
                SC_SHOW: begin
                    tick_q <= tick_q + 1'b1;
                    if (tick_q == TW'(PWM_TICKS - 1)) begin
                        row_q   <= (row_q == YW'(FB_H - 1)) ? '0 : row_q + 1'b1;
                        state_q <= SC_SEL;
                    end
                end
                default: state_q <= SC_SEL;
            endcase
        end
    end

endmodule

// File: rtl/disp_ctrl.sv
module disp_ctrl #(
    parameter int FB_W      = 64,
    parameter int FB_H      = 32,
    parameter int PWM_TICKS = 16,
    parameter int BRIGHT    = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_stb,
    input  logic [7:0]              wr_data,
    input  logic                    clr_cmd,
    output logic                    draw_done,
    output logic                    coll_flag,
    output logic [$clog2(FB_H)-1:0] row_sel,
    output logic                    col_sdat,
    output logic                    col_sclk,
    output logic                    col_latch,
    output logic                    row_oe
);

    localparam int YW = $clog2(FB_H);

    logic            fb_we;
    logic [YW-1:0]   fb_waddr;
    logic [FB_W-1:0] fb_wmask;
    logic [FB_W-1:0] fb_wold;
    logic [YW-1:0]   fb_raddr;
    logic [FB_W-1:0] fb_rdata;

    disp_rx #(.FB_W(FB_W), .FB_H(FB_H)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .stb      (wr_stb),
        .din      (wr_data),
        .clr      (clr_cmd),
        .fb_we    (fb_we),
        .fb_waddr (fb_waddr),
        .fb_wmask (fb_wmask),
        .fb_old   (fb_wold),
        .done     (draw_done),
        .coll     (coll_flag)
    );

    disp_fb #(.FB_W(FB_W), .FB_H(FB_H)) u_fb (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_cmd),
        .we    (fb_we),
        .waddr (fb_waddr),
        .wmask (fb_wmask),
        .wold  (fb_wold),
        .raddr (fb_raddr),
        .rdata (fb_rdata)
    );

    disp_scan #(.FB_W(FB_W), .FB_H(FB_H), .PWM_TICKS(PWM_TICKS), .BRIGHT(BRIGHT)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .raddr     (fb_raddr),
        .rdata     (fb_rdata),
        .row_sel   (row_sel),
        .col_sdat  (col_sdat),
        .col_sclk  (col_sclk),
        .col_latch (col_latch),
        .row_oe    (row_oe)
    );

endmodule

// File: rtl/disp_ctrl_chk.sv
module disp_ctrl_chk #(
    parameter int YW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          clr_cmd,
    input logic          draw_done,
    input logic          coll_flag,
    input logic [YW-1:0] row_sel,
    input logic          col_sclk,
    input logic          col_latch,
    input logic          row_oe
);

    // R8: enable is dark while shifting or latching
    a_r8_dark_outside_show: assert property (@(posedge clk) disable iff (rst)
        row_oe |-> (!col_sclk && !col_latch));

    // R8: row selection only moves while the row is dark
    a_r8_row_move_dark: assert property (@(posedge clk) disable iff (rst)
        (row_sel != $past(row_sel)) |-> (!row_oe && !col_sclk));

    // R7: latch is a single-cycle pulse
    a_r7_latch_pulse: assert property (@(posedge clk) disable iff (rst)
        col_latch |=> !col_latch);

    // R4: completion is a single-cycle pulse
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
        draw_done |=> !draw_done);

    // R4: collision result only moves on a completion or after a clear
    a_r4_flag_hold: assert property (@(posedge clk) disable iff (rst)
        (coll_flag != $past(coll_flag)) |-> (draw_done || $past(clr_cmd)));

    // R6: a clear zeroes the result and raises no completion
    a_r6_clear_result: assert property (@(posedge clk) disable iff (rst)
        clr_cmd |=> (!coll_flag && !draw_done));

endmodule

bind disp_ctrl disp_ctrl_chk #(.YW($clog2(FB_H))) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr_cmd   (clr_cmd),
    .draw_done (draw_done),
    .coll_flag (coll_flag),
    .row_sel   (row_sel),
    .col_sclk  (col_sclk),
    .col_latch (col_latch),
    .row_oe    (row_oe)
);

// File: tb/tb_disp_ctrl.sv
module tb_disp_ctrl;

    localparam int CLK_P     = 10;
    localparam int W         = 64;
    localparam int H         = 32;
    localparam int PWM_TICKS = 16;
    localparam int BRIGHT    = 10;
    localparam int FRAME     = H * (2 + 2 * W + PWM_TICKS);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic       clr_cmd = 1'b0;
    logic       draw_done, coll_flag, col_sdat, col_sclk, col_latch, row_oe;
    logic [4:0] row_sel;

    disp_ctrl #(.FB_W(W), .FB_H(H), .PWM_TICKS(PWM_TICKS), .BRIGHT(BRIGHT)) dut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data), .clr_cmd(clr_cmd),
        .draw_done(draw_done), .coll_flag(coll_flag), .row_sel(row_sel),
        .col_sdat(col_sdat), .col_sclk(col_sclk), .col_latch(col_latch), .row_oe(row_oe)
    );

    always #(CLK_P / 2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [W-1:0] img [H];      // bench model
    logic [W-1:0] cap_img [H];  // image rebuilt from refresh stream
    logic [7:0]   spr [15];

    // ---------------- refresh stream monitor ----------------
    logic [W-1:0] sh_cap;
    int colcnt = 0, oecnt = 0, latches = 0, last_row = -1;
    int mon_seq_bad = 0, mon_duty_bad = 0, mon_dark_bad = 0;

    always @(negedge clk) begin
        if (rst) begin
            colcnt = 0; oecnt = 0; latches = 0; last_row = -1;
            for (int r = 0; r < H; r++) cap_img[r] = 'x;
        end else begin
            if (row_oe && (col_sclk || col_latch)) mon_dark_bad++;
            if (row_oe) oecnt++;
            if (col_sclk) begin
                if (colcnt < W) sh_cap[colcnt] = col_sdat;
                colcnt++;
            end
            if (col_latch) begin
                if (colcnt != W) mon_seq_bad++;
                if (int'(row_sel) != ((last_row + 1) % H)) mon_seq_bad++;
                if (latches > 0 && oecnt != BRIGHT) mon_duty_bad++;
                cap_img[row_sel] = sh_cap;
                last_row = int'(row_sel);
                latches++;
                colcnt = 0;
                oecnt = 0;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit model_draw(input logic [7:0] hdr, input logic [7:0] xb,
                                      input logic [7:0] yb);
        bit c = 0;
        int n = int'(hdr[3:0]);
        int x = int'(xb) % W;
        int y = int'(yb) % H;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 8; k++) begin
                if (spr[i][7-k]) begin
                    int cc = (x + k) % W;
                    int rr = (y + i) % H;
                    if (img[rr][cc]) c = 1;
                    img[rr][cc] = ~img[rr][cc];
                end
            end
        end
        return c;
    endfunction

    task automatic put_byte(input logic [7:0] b, input int gap);
        repeat (gap) @(negedge clk);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    // Full draw; checks the done pulse and flag in the cycle after the last strobe.
    task automatic do_draw(input logic [7:0] hdr, input logic [7:0] xb,
                           input logic [7:0] yb, input int gap, input string req);
        bit  expc;
        int  n = int'(hdr[3:0]);
        expc = model_draw(hdr, xb, yb);
        put_byte(hdr, gap);
        put_byte(xb, gap);
        if (n == 0) begin
            repeat (gap) @(negedge clk);
            @(negedge clk);
            wr_stb = 1'b1; wr_data = yb;
        end else begin
            put_byte(yb, gap);
            for (int i = 0; i < n - 1; i++) put_byte(spr[i], gap);
            repeat (gap) @(negedge clk);
            @(negedge clk);
            wr_stb = 1'b1; wr_data = spr[n-1];
        end
        @(negedge clk);
        wr_stb = 1'b0;
        chk(draw_done == 1'b1, req, "done pulse after last byte", 64'(draw_done), 64'd1);
        chk(coll_flag == expc, req, "collision flag", 64'(coll_flag), 64'(expc));
    endtask

    task automatic check_image(input string req, input string what);
        int mism = -1;
        repeat (2 * FRAME + 50) @(negedge clk);
        for (int r = 0; r < H; r++) begin
            if (mism < 0 && cap_img[r] !== img[r]) mism = r;
        end
        if (mism < 0) chk(1'b1, req, what, 64'd0, 64'd0);
        else chk(1'b0, req, {what, " row mismatch"}, cap_img[mism], img[mism]);
    endtask

    task automatic do_clear(input bit with_stb, input logic [7:0] b);
        @(negedge clk);
        clr_cmd = 1'b1;
        wr_stb  = with_stb;
        wr_data = b;
        @(negedge clk);
        clr_cmd = 1'b0;
        wr_stb  = 1'b0;
        for (int r = 0; r < H; r++) img[r] = '0;
        chk(coll_flag == 1'b0, "R6", "flag after clear", 64'(coll_flag), 64'd0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        for (int r = 0; r < H; r++) img[r] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(coll_flag == 0 && draw_done == 0, "R4", "reset outputs", 64'({draw_done, coll_flag}), 64'd0);
        check_image("R9", "reset image blank");

        // R2 R3: 15 lines at the bottom-right corner, wrapping both ways
        for (int i = 0; i < 15; i++) spr[i] = 8'hA5 ^ 8'(i * 17);
        do_draw(8'h0F, 8'd60, 8'd30, 0, "R3");
        check_image("R3", "corner wrap draw");

        // R1 R3: upper header nibble ignored, upper X/Y bits ignored
        spr[0] = 8'hFF; spr[1] = 8'h81; spr[2] = 8'h3C;
        do_draw(8'hF3, 8'hC5, 8'h25, 2, "R1");
        check_image("R1", "header nibble and coordinate masking");

        // R4 R2: same sprite again erases it and collides
        do_draw(8'h03, 8'd5, 8'd5, 0, "R4");
        // R4: disjoint sprite -> no collision
        spr[0] = 8'h18;
        do_draw(8'h01, 8'd20, 8'd12, 1, "R4");
        check_image("R2", "xor erase and disjoint draw");

        // R5: zero-height draw
        do_draw(8'h00, 8'd20, 8'd12, 0, "R5");
        check_image("R5", "zero height leaves image");

        // R6: clear, then clear with strobe and mid-draw abort
        do_clear(1'b0, 8'h00);
        check_image("R6", "clear blanks image");
        put_byte(8'h02, 0);
        put_byte(8'd7, 0);
        do_clear(1'b0, 8'h00);
        do_clear(1'b1, 8'h04);
        spr[0] = 8'hC3; spr[1] = 8'h7E;
        do_draw(8'h02, 8'd33, 8'd17, 0, "R6");
        check_image("R6", "abort and strobe-on-clear discarded");

        // R1 R2 R4: random draws with random gaps
        for (int t = 0; t < 24; t++) begin
            logic [7:0] h, xb, yb;
            h  = 8'($urandom_range(0, 255));
            xb = 8'($urandom_range(0, 255));
            yb = 8'($urandom_range(0, 255));
            for (int i = 0; i < 15; i++) spr[i] = 8'($urandom_range(0, 255));
            do_draw(h, xb, yb, int'($urandom_range(0, 2)), "R4");
            if (t % 8 == 7) check_image("R2", "random draws");
        end

        // R7 R8: refresh stream discipline from monitor
        chk(latches > 3 * H, "R7", "rows latched", 64'(latches), 64'(3 * H));
        chk(mon_seq_bad == 0, "R7", "row order and bit count errors", 64'(mon_seq_bad), 64'd0);
        chk(mon_duty_bad == 0, "R8", "enable duty errors", 64'(mon_duty_bad), 64'd0);
        chk(mon_dark_bad == 0, "R8", "enable during shift/latch", 64'(mon_dark_bad), 64'd0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule